// File: doc/BRIEF.md
# Compressed Halfword Decoder with Mode Tracking

This block sits right after instruction fetch. It accepts one 16-bit parcel per handshake and produces one registered record per parcel. It keeps track of which of three states the instruction stream is in. The first state is the first half of a normal 32-bit word, which is where each word starts. The second is the second half of such a word. The third is a run of compressed halfwords. Parcels that belong to a 32-bit word leave the block untouched, with a passthrough flag set.

One reserved value in the top five bits of a word-start parcel enters compressed operation. That entering halfword has only ten usable operation bits. The halfwords that follow it are decoded with their top five bits used as most-significant extensions of the register, condition and offset fields.

Each compressed halfword becomes an expanded record. The record holds an operation class, the register fields, the condition-register fields, a branch offset, a link flag, a zero-operand flag and an illegal flag. Bit numbering in this brief counts bit 0 as the most significant bit of the parcel, so bit k is `parcel[15-k]`. Operation class codes are the values of the enumeration `op_e` in the package.

Top module: `cmp_parcel_dec`

## Requirements
- R1: While reset is high, and at the first cycle after it, `out_valid` is 0 and `in_ready` is 1. The first parcel after reset is treated as the start of a 32-bit word.
- R2: A word-start parcel whose bits 0–4 differ from `MAJOR_OP` gives a passthrough record with `out_pass`=1 and `out_raw` equal to the parcel. The next parcel is also passed through whatever it contains, and the parcel after that is a word start again.
- R3: A word-start parcel whose bits 0–4 equal `MAJOR_OP` is decoded in 10-bit mode. Bit 15 of any compressed halfword is a continuation flag: when it is 1 the next parcel is decoded in 16-bit mode, and when it is 0 the next parcel is a word start.
- R4: A halfword that is unallocated, or illegal in its mode, gives `out_ill`=1 with op `OP_ILL` and every other field 0. The next parcel is then a word start, even when bit 15 is set.
- R5: Bits 5–7 select the group: 010 add/mul, 011 sub/fsub, 100 and/nand, 101 or/nor, 110 fadd/fmul, with bit 14 choosing the second of each pair. In these groups RB is bits 8–10 and RA is bits 11–13. RT is bits 2–4 in 16-bit mode and equals RB in 10-bit mode.
- R6: `out_zero`=1 exactly when RA=0 selects a zero operand instead of a register. This applies to sub, fsub and nor, and also to every store (its offset is zero).
- R7: In group 100 with bit 14=0 and RA=0, bits 8–10 equal to 000 give `OP_SC`, 001 give `OP_RFID`, and any other value is unallocated. In group 110 with bit 14=0 and RA=0 the op is `OP_FABS`.
- R8: Group 000 is a relative branch with link flag in bit 14. Its halfword offset is bits 8–13 as a signed 6-bit value in 10-bit mode. In 16-bit mode bits 0–1 are prepended as MSBs, giving a signed 8-bit value. The offset appears sign-extended on `out_imm`.
- R9: Group 001 with bit 8=0 is a branch to LR (bit 11=0) or to TAR (bit 11=1), with the link flag in bit 14. BI is bits 9–10 and BO is bits 12–13. In 16-bit mode bits 2–4 extend BI and bits 0–1 extend BO as MSBs.
- R10: In group 111, bit 14 = 0 is a load and bit 14 = 1 is a store. RA is bits 9–10 and the second register is bits 12–13. In 16-bit mode, bit 0 selects the float form, bit 1 is the RA MSB, a load takes RT from bits 2–4, and a store takes its RT MSB from bit 2. In 10-bit mode a load writes RT=RB, and no float form exists.
- R11: Group 001 with bit 8=1 is illegal in 10-bit mode. In 16-bit mode (bit 11 must be 0) bits 0–3 pick mcrf (0000), the CR logic ops, or moves (1111, bit 4=1 for move-from, bits 9–10 selecting LR/CTR/TAR/CR). The prefixes 0010, 0011, 0101, 1010, 1011 and 1100 are unallocated. A CR logic op has destination equal to BA = {bit 4, bits 9–10}.
- R12: `in_ready` equals `!out_valid || out_ready`. While the output is stalled, the record and the mode state hold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Parcel offered |
| in_ready | output | 1 | Parcel accepted this cycle when valid |
| in_parcel | input | 16 | Fetched parcel, bit 0 = MSB |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_pass | output | 1 | Record is an undecoded 32-bit half |
| out_raw | output | 16 | Parcel the record came from |
| out_op | output | 6 | Operation class code |
| out_rt | output | 3 | Target register |
| out_ra | output | 3 | RA register |
| out_rb | output | 3 | RB register |
| out_cra | output | 5 | First CR source field/bit |
| out_crb | output | 5 | Second CR source bit |
| out_crt | output | 5 | CR destination field/bit |
| out_bo | output | 4 | Branch condition options |
| out_bi | output | 5 | Branch condition bit |
| out_imm | output | IMM_W | Sign-extended halfword offset |
| out_link | output | 1 | Branch writes link |
| out_zero | output | 1 | Zero operand in place of RA |
| out_ill | output | 1 | Illegal or unallocated halfword |

## Verification
The bench builds the block with `MAJOR_OP` set to 5'b01101, not the default, and with `IMM_W` set to 12. The first setting shows that entry depends only on the parameter, including when the same bit pattern appears in a second word half. The second setting makes the offset sign extension cross a width other than 16. With these values, long random runs reach chains of compressed halfwords ended both by a clear continuation bit and by an illegal halfword. The random output stalls hold the mode state across accepted and refused parcels.

// File: rtl/cmp_dec_pkg.sv
package cmp_dec_pkg;

  typedef enum logic [5:0] {
    OP_PASS, OP_ILL, OP_B, OP_BCLR, OP_BCTAR,
    OP_LD, OP_ST, OP_FLD, OP_FST,
    OP_ADD, OP_MUL, OP_SUB, OP_FSUB, OP_AND, OP_NAND, OP_OR, OP_NOR,
    OP_FADD, OP_FMUL, OP_FABS, OP_SC, OP_RFID,
    OP_MCRF, OP_CRNOR, OP_CRANDC, OP_CRXOR, OP_CRNAND, OP_CRAND,
    OP_CREQV, OP_CRORC, OP_CROR,
    OP_MTLR, OP_MTCTR, OP_MTTAR, OP_MTCR,
    OP_MFLR, OP_MFCTR, OP_MFTAR, OP_MFCR
  } op_e;

  typedef enum logic [1:0] {MD_WORD_HI, MD_WORD_LO, MD_HALF} mode_e;

  localparam int OFF_W = 8;

  typedef struct packed {
    op_e              op;
    logic [2:0]       rt;
    logic [2:0]       ra;
    logic [2:0]       rb;
    logic [4:0]       cra;
    logic [4:0]       crb;
    logic [4:0]       crt;
    logic [3:0]       bo;
    logic [4:0]       bi;
    logic [OFF_W-1:0] off;
    logic             link;
    logic             zero;
    logic             ill;
  } dec_t;

endpackage

// File: rtl/cmp_field_dec.sv
module cmp_field_dec
  import cmp_dec_pkg::*;
(
  input  logic        wide,
  input  logic [0:14] op_bits,
  output dec_t        dec
);
  logic [0:14] p;
  logic [2:0]  ra3, rb3;
  logic        bad;
  logic        crl;
  assign p   = op_bits;
  assign rb3 = p[8:10];
  assign ra3 = p[11:13];

  always_comb begin
    dec = '0;
    bad = 1'b0;
    crl = 1'b0;
    case (p[5:7])
      3'b000: begin
        dec.op   = OP_B;
        dec.off  = wide ? {p[0:1], p[8:13]} : {{2{p[8]}}, p[8:13]};
        dec.link = p[14];
      end
      3'b001: begin
        if (!p[8]) begin
          dec.op   = p[11] ? OP_BCTAR : OP_BCLR;
          dec.bi   = wide ? {p[2:4], p[9:10]} : {3'b000, p[9:10]};
          dec.bo   = wide ? {p[0:1], p[12:13]} : {2'b00, p[12:13]};
          dec.link = p[14];
        end else if (!wide || p[11]) begin
          bad = 1'b1;
        end else begin
          case (p[0:3])
            4'b0000: begin
              dec.op  = OP_MCRF;
              dec.crt = {2'b00, p[4], p[9:10]};
              dec.cra = {3'b000, p[12:13]};
            end
            4'b0001: begin dec.op = OP_CRNOR;  crl = 1'b1; end
            4'b0100: begin dec.op = OP_CRANDC; crl = 1'b1; end
            4'b0110: begin dec.op = OP_CRXOR;  crl = 1'b1; end
            4'b0111: begin dec.op = OP_CRNAND; crl = 1'b1; end
            4'b1000: begin dec.op = OP_CRAND;  crl = 1'b1; end
            4'b1001: begin dec.op = OP_CREQV;  crl = 1'b1; end
            4'b1101: begin dec.op = OP_CRORC;  crl = 1'b1; end
            4'b1110: begin dec.op = OP_CROR;   crl = 1'b1; end
            4'b1111: begin
              if (!p[4]) begin
                dec.rt = {1'b0, p[12:13]};
                case (p[9:10])
                  2'b00:   dec.op = OP_MTLR;
                  2'b01:   dec.op = OP_MTCTR;
                  2'b10:   dec.op = OP_MTTAR;
                  default: dec.op = OP_MTCR;
                endcase
              end else begin
                dec.ra = {1'b0, p[12:13]};
                case (p[9:10])
                  2'b00:   dec.op = OP_MFLR;
                  2'b01:   dec.op = OP_MFCTR;
                  2'b10:   dec.op = OP_MFTAR;
                  default: dec.op = OP_MFCR;
                endcase
              end
            end
            default: bad = 1'b1;
          endcase
          if (crl) begin
            dec.cra = {2'b00, p[4], p[9:10]};
            dec.crb = {2'b00, p[4], p[12:13]};
            dec.crt = {2'b00, p[4], p[9:10]};
          end
        end
      end
      3'b111: begin
        dec.ra = {wide & p[1], p[9:10]};
        if (!p[14]) begin
          dec.op = (wide && p[0]) ? OP_FLD : OP_LD;
          dec.rb = {1'b0, p[12:13]};
          dec.rt = wide ? p[2:4] : {1'b0, p[12:13]};
        end else begin
          dec.op   = (wide && p[0]) ? OP_FST : OP_ST;
          dec.rt   = {wide & p[2], p[12:13]};
          dec.zero = 1'b1;
        end
      end
      default: begin
        if (p[5:7] == 3'b100 && ra3 == 3'b000 && !p[14]) begin
          if (rb3 == 3'b000)      dec.op = OP_SC;
          else if (rb3 == 3'b001) dec.op = OP_RFID;
          else                    bad = 1'b1;
        end else begin
          dec.rb = rb3;
          dec.ra = ra3;
          dec.rt = wide ? p[2:4] : rb3;
          case (p[5:7])
            3'b010: dec.op = p[14] ? OP_MUL : OP_ADD;
            3'b011: begin
              dec.op   = p[14] ? OP_FSUB : OP_SUB;
              dec.zero = (ra3 == 3'b000);
            end
            3'b100: dec.op = p[14] ? OP_NAND : OP_AND;
            3'b101: begin
              dec.op   = p[14] ? OP_NOR : OP_OR;
              dec.zero = p[14] && (ra3 == 3'b000);
            end
            default: dec.op = p[14] ? OP_FMUL :
                              ((ra3 == 3'b000) ? OP_FABS : OP_FADD);
          endcase
        end
      end
    endcase
    if (bad) begin
      dec     = '0;
      dec.op  = OP_ILL;
      dec.ill = 1'b1;
    end
  end
endmodule

// File: rtl/cmp_mode_ctl.sv
module cmp_mode_ctl
  import cmp_dec_pkg::*;
#(
  parameter logic [4:0] MAJOR_OP = 5'b11110
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  logic [4:0] major,
  input  logic       cont,
  input  logic       bad,
  output logic       is_comp,
  output logic       wide
);
  mode_e md;

  assign wide    = (md == MD_HALF);
  assign is_comp = wide || (md == MD_WORD_HI && major == MAJOR_OP);

  always_ff @(posedge clk) begin
    if (rst) begin
      md <= MD_WORD_HI;
    end else if (adv) begin
      if (!is_comp)
        md <= (md == MD_WORD_HI) ? MD_WORD_LO : MD_WORD_HI;
      else
        md <= (cont && !bad) ? MD_HALF : MD_WORD_HI;
    end
  end
endmodule

// File: rtl/cmp_parcel_dec.sv
module cmp_parcel_dec
  import cmp_dec_pkg::*;
#(
  parameter logic [4:0] MAJOR_OP = 5'b11110,
  parameter int         IMM_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [15:0]      in_parcel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_pass,
  output logic [15:0]      out_raw,
  output logic [5:0]       out_op,
  output logic [2:0]       out_rt,
  output logic [2:0]       out_ra,
  output logic [2:0]       out_rb,
  output logic [4:0]       out_cra,
  output logic [4:0]       out_crb,
  output logic [4:0]       out_crt,
  output logic [3:0]       out_bo,
  output logic [4:0]       out_bi,
  output logic [IMM_W-1:0] out_imm,
  output logic             out_link,
  output logic             out_zero,
  output logic             out_ill
);
  localparam dec_t PASS_REC = '0;

  dec_t dec, q;
  logic is_comp, wide, adv;

  assign in_ready = !out_valid || out_ready;
  assign adv      = in_valid && in_ready;

  cmp_field_dec u_field (
    .wide    (wide),
    .op_bits (in_parcel[15:1]),
    .dec     (dec)
  );

  cmp_mode_ctl #(.MAJOR_OP(MAJOR_OP)) u_mode (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .major   (in_parcel[15:11]),
    .cont    (in_parcel[0]),
    .bad     (dec.ill),
    .is_comp (is_comp),
    .wide    (wide)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pass  <= 1'b0;
      out_raw   <= '0;
      q         <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_raw  <= in_parcel;
        out_pass <= !is_comp;
        q        <= is_comp ? dec : PASS_REC;
      end
    end
  end

  assign out_op   = q.op;
  assign out_rt   = q.rt;
  assign out_ra   = q.ra;
  assign out_rb   = q.rb;
  assign out_cra  = q.cra;
  assign out_crb  = q.crb;
  assign out_crt  = q.crt;
  assign out_bo   = q.bo;
  assign out_bi   = q.bi;
  assign out_link = q.link;
  assign out_zero = q.zero;
  assign out_ill  = q.ill;

  generate
    if (IMM_W > OFF_W) begin : g_sext
      assign out_imm = {{(IMM_W-OFF_W){q.off[OFF_W-1]}}, q.off};
    end else begin : g_trunc
      assign out_imm = q.off[IMM_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/cmp_parcel_dec_chk.sv
module cmp_parcel_dec_chk
  import cmp_dec_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_pass,
  input logic [15:0] out_raw,
  input logic [5:0]  out_op,
  input logic        out_link,
  input logic        out_zero,
  input logic        out_ill
);
  // R1
  rst_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && in_ready));

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_raw) && $stable(out_op)
                                   && $stable(out_pass)));

  // R4
  ill_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ill) |-> (!out_pass && !out_link && !out_zero
                                && out_op == OP_ILL));

  // R6
  zero_ops_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_zero) |-> (out_op == OP_SUB || out_op == OP_FSUB ||
                                 out_op == OP_NOR || out_op == OP_ST ||
                                 out_op == OP_FST));

  // R8
  link_ops_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_link) |-> (out_op == OP_B || out_op == OP_BCLR ||
                                 out_op == OP_BCTAR));

  // R2
  pass_rec_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_pass) |-> (out_op == OP_PASS && !out_ill));
endmodule

bind cmp_parcel_dec cmp_parcel_dec_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pass  (out_pass),
  .out_raw   (out_raw),
  .out_op    (out_op),
  .out_link  (out_link),
  .out_zero  (out_zero),
  .out_ill   (out_ill)
);

// File: tb/cmp_parcel_dec_tb_top.sv
module cmp_parcel_dec_tb_top;
  import cmp_dec_pkg::*;

  localparam logic [4:0] MAJ   = 5'b01101;
  localparam int         IMM_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [15:0] in_parcel = '0;
  logic out_valid, out_ready = 1'b0;
  logic out_pass, out_link, out_zero, out_ill;
  logic [15:0] out_raw;
  logic [5:0] out_op;
  logic [2:0] out_rt, out_ra, out_rb;
  logic [4:0] out_cra, out_crb, out_crt, out_bi;
  logic [3:0] out_bo;
  logic [IMM_W-1:0] out_imm;

  always #4 clk = ~clk;

  cmp_parcel_dec #(.MAJOR_OP(MAJ), .IMM_W(IMM_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_parcel(in_parcel), .out_valid(out_valid), .out_ready(out_ready),
    .out_pass(out_pass), .out_raw(out_raw), .out_op(out_op),
    .out_rt(out_rt), .out_ra(out_ra), .out_rb(out_rb),
    .out_cra(out_cra), .out_crb(out_crb), .out_crt(out_crt),
    .out_bo(out_bo), .out_bi(out_bi), .out_imm(out_imm),
    .out_link(out_link), .out_zero(out_zero), .out_ill(out_ill));

  typedef struct {
    bit pass, ill, link, zero;
    op_e op;
    int rt, ra, rb, cra, crb, crt, bo, bi, imm;
    logic [15:0] raw;
  } exp_t;

  int checks = 0, errors = 0;
  int mstate = 0;           // 0 word start, 1 word second half, 2 compressed run
  logic [15:0] pq[$];
  exp_t eq[$];
  bit done = 0;

  function automatic int fld(logic [15:0] h, int a, int b);
    return int'((h >> (15 - b)) & ((16'h1 << (b - a + 1)) - 1));
  endfunction

  function automatic logic [15:0] hw(logic [4:0] hi, logic [2:0] g, logic [5:0] mid,
                                     logic b14, logic b15);
    return {hi, g, mid, b14, b15};
  endfunction

  function automatic exp_t model(logic [15:0] h, bit w);
    exp_t e;
    int g, ra, rb, b14, off, pre, x, a, b, sec;
    bit bad;
    op_e mt[4], mf[4];
    mt = '{OP_MTLR, OP_MTCTR, OP_MTTAR, OP_MTCR};
    mf = '{OP_MFLR, OP_MFCTR, OP_MFTAR, OP_MFCR};
    e = '{pass:0, ill:0, link:0, zero:0, op:OP_PASS, rt:0, ra:0, rb:0, cra:0,
          crb:0, crt:0, bo:0, bi:0, imm:0, raw:h};
    bad = 0;
    g = fld(h,5,7); rb = fld(h,8,10); ra = fld(h,11,13); b14 = fld(h,14,14);
    if (g == 0) begin
      if (w) begin off = fld(h,0,1)*64 + fld(h,8,13); if (off >= 128) off -= 256; end
      else   begin off = fld(h,8,13); if (off >= 32) off -= 64; end
      e.op = OP_B; e.imm = off; e.link = (b14 != 0);
    end else if (g == 1) begin
      if (fld(h,8,8) == 0) begin
        e.op = fld(h,11,11) ? OP_BCTAR : OP_BCLR;
        e.bi = fld(h,9,10) + (w ? fld(h,2,4)*4 : 0);
        e.bo = fld(h,12,13) + (w ? fld(h,0,1)*4 : 0);
        e.link = (b14 != 0);
      end else if (!w || fld(h,11,11) != 0) bad = 1;
      else begin
        pre = fld(h,0,3); x = fld(h,4,4); a = fld(h,9,10); b = fld(h,12,13);
        case (pre)
          0: begin e.op = OP_MCRF; e.crt = x*4 + a; e.cra = b; end
          15: if (x == 0) begin e.op = mt[a]; e.rt = b; end
              else begin e.op = mf[a]; e.ra = b; end
          1, 4, 6, 7, 8, 9, 13, 14: begin
            case (pre)
              1: e.op = OP_CRNOR;  4: e.op = OP_CRANDC; 6: e.op = OP_CRXOR;
              7: e.op = OP_CRNAND; 8: e.op = OP_CRAND;  9: e.op = OP_CREQV;
              13: e.op = OP_CRORC; default: e.op = OP_CROR;
            endcase
            e.cra = x*4 + a; e.crb = x*4 + b; e.crt = e.cra;
          end
          default: bad = 1;
        endcase
      end
    end else if (g == 7) begin
      sec = fld(h,12,13);
      e.ra = (w ? fld(h,1,1)*4 : 0) + fld(h,9,10);
      if (b14 == 0) begin
        e.op = (w && fld(h,0,0) != 0) ? OP_FLD : OP_LD;
        e.rb = sec; e.rt = w ? fld(h,2,4) : sec;
      end else begin
        e.op = (w && fld(h,0,0) != 0) ? OP_FST : OP_ST;
        e.rt = (w ? fld(h,2,2)*4 : 0) + sec; e.zero = 1;
      end
    end else if (g == 4 && ra == 0 && b14 == 0) begin
      if (rb == 0) e.op = OP_SC;
      else if (rb == 1) e.op = OP_RFID;
      else bad = 1;
    end else begin
      e.ra = ra; e.rb = rb; e.rt = w ? fld(h,2,4) : rb;
      case (g)
        2: e.op = b14 ? OP_MUL : OP_ADD;
        3: begin e.op = b14 ? OP_FSUB : OP_SUB; e.zero = (ra == 0); end
        4: e.op = b14 ? OP_NAND : OP_AND;
        5: begin e.op = b14 ? OP_NOR : OP_OR; e.zero = (b14 != 0 && ra == 0); end
        default: e.op = b14 ? OP_FMUL : (ra == 0 ? OP_FABS : OP_FADD);
      endcase
    end
    if (bad) begin
      e = '{pass:0, ill:1, link:0, zero:0, op:OP_ILL, rt:0, ra:0, rb:0, cra:0,
            crb:0, crt:0, bo:0, bi:0, imm:0, raw:h};
    end
    return e;
  endfunction

  task automatic push(logic [15:0] h);
    exp_t e;
    if (mstate == 2 || (mstate == 0 && fld(h,0,4) == int'(MAJ))) begin
      e = model(h, mstate == 2);
      mstate = (fld(h,15,15) != 0 && !e.ill) ? 2 : 0;
    end else begin
      e = model(h, 0);
      e = '{pass:1, ill:0, link:0, zero:0, op:OP_PASS, rt:0, ra:0, rb:0, cra:0,
            crb:0, crt:0, bo:0, bi:0, imm:0, raw:h};
      mstate = (mstate == 0) ? 1 : 0;
    end
    pq.push_back(h);
    eq.push_back(e);
  endtask

  function automatic string tag_of(exp_t e);
    case (e.op)
      OP_PASS: return "R2";
      OP_ILL: return "R4";
      OP_B: return "R8";
      OP_BCLR, OP_BCTAR: return "R9";
      OP_LD, OP_ST, OP_FLD, OP_FST: return "R10";
      OP_SC, OP_RFID, OP_FABS: return "R7";
      OP_ADD, OP_MUL, OP_SUB, OP_FSUB, OP_AND, OP_NAND, OP_OR, OP_NOR,
      OP_FADD, OP_FMUL: return e.zero ? "R6" : "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic check_rec(exp_t e);
    int ai;
    bit ok;
    ai = $signed(out_imm);
    checks++;   // R3: mode decides passthrough vs decode
    if (out_pass != e.pass || out_raw != e.raw) begin
      errors++;
      $display("FAIL R3 mode raw=%h: pass act=%0b exp=%0b raw act=%h",
               e.raw, out_pass, e.pass, out_raw);
    end
    ok = (out_op == e.op) && (out_ill == e.ill) && (out_link == e.link) &&
         (out_zero == e.zero) && (int'(out_rt) == e.rt) && (int'(out_ra) == e.ra) &&
         (int'(out_rb) == e.rb) && (int'(out_cra) == e.cra) &&
         (int'(out_crb) == e.crb) && (int'(out_crt) == e.crt) &&
         (int'(out_bo) == e.bo) && (int'(out_bi) == e.bi) && (ai == e.imm);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s raw=%h act op=%0d rt=%0d ra=%0d rb=%0d cr=%0d/%0d/%0d bo=%0d bi=%0d imm=%0d l=%0b z=%0b i=%0b exp op=%0d rt=%0d ra=%0d rb=%0d cr=%0d/%0d/%0d bo=%0d bi=%0d imm=%0d l=%0b z=%0b i=%0b",
               tag_of(e), e.raw, out_op, out_rt, out_ra, out_rb, out_cra, out_crb,
               out_crt, out_bo, out_bi, ai, out_link, out_zero, out_ill,
               e.op, e.rt, e.ra, e.rb, e.cra, e.crb, e.crt, e.bo, e.bi, e.imm,
               e.link, e.zero, e.ill);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=hung exp=drained queue");
      summary();
    end
  end

  initial begin
    bit acc, stall;
    logic [15:0] s_raw;
    logic [5:0] s_op;
    acc = 0; stall = 0; s_raw = '0; s_op = '0;
    repeat (3) @(negedge clk);
    checks++;   // R1 during reset
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R1 out_valid in reset act=%b exp=0", out_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;   // R1 after reset
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 after reset act valid=%b ready=%b exp 0/1", out_valid, in_ready);
    end

    // R2: word halves, second one carrying the entry pattern
    push(16'h1234); push(16'h6800);
    // R3 R5 R6 R7 R4: 10-bit entry, 16-bit run, ended by unallocated system code
    push(hw(MAJ, 3'b010, 6'b101011, 1'b0, 1'b1));
    push(hw(5'b00110, 3'b010, 6'b001010, 1'b1, 1'b1));
    push(hw(5'b00011, 3'b011, 6'b010000, 1'b1, 1'b1));
    push(hw(5'b00001, 3'b101, 6'b111000, 1'b1, 1'b1));
    push(hw(5'b00000, 3'b100, 6'b000000, 1'b0, 1'b1));
    push(hw(5'b00000, 3'b100, 6'b001000, 1'b0, 1'b1));
    push(hw(5'b00000, 3'b100, 6'b010000, 1'b0, 1'b1));
    push(16'h0F0F); push(16'h0000);
    // R8 R9 R11: branches, CR ops, moves, unused prefix
    push(hw(MAJ, 3'b000, 6'b111110, 1'b1, 1'b1));
    push(hw(5'b10000, 3'b000, 6'b000001, 1'b0, 1'b1));
    push(hw(5'b11101, 3'b001, 6'b010001, 1'b1, 1'b1));
    push(hw(5'b00000, 3'b001, 6'b001110, 1'b0, 1'b1));
    push(hw(5'b00001, 3'b001, 6'b110011, 1'b0, 1'b1));
    push(hw(5'b01100, 3'b001, 6'b101010, 1'b0, 1'b1));
    push(hw(5'b11110, 3'b001, 6'b101011, 1'b0, 1'b1));
    push(hw(5'b11111, 3'b001, 6'b111010, 1'b0, 1'b1));
    push(hw(5'b01010, 3'b001, 6'b100000, 1'b0, 1'b1));
    // R11: CR op in 10-bit mode is illegal
    push(hw(MAJ, 3'b001, 6'b100000, 1'b0, 1'b1));
    push(16'h2222); push(16'h3333);
    // R10 R7 R5 R6: loads, stores, float ops, logic ops, sub ends the run
    push(hw(MAJ, 3'b111, 6'b010011, 1'b0, 1'b1));
    push(hw(5'b01101, 3'b111, 6'b001010, 1'b0, 1'b1));
    push(hw(5'b10011, 3'b111, 6'b011001, 1'b1, 1'b1));
    push(hw(5'b11000, 3'b111, 6'b000000, 1'b0, 1'b1));
    push(hw(5'b00000, 3'b110, 6'b011000, 1'b0, 1'b1));
    push(hw(5'b00100, 3'b110, 6'b011001, 1'b0, 1'b1));
    push(hw(5'b00100, 3'b110, 6'b011000, 1'b1, 1'b1));
    push(hw(5'b00010, 3'b100, 6'b010001, 1'b0, 1'b1));
    push(hw(5'b00010, 3'b100, 6'b010000, 1'b1, 1'b1));
    push(hw(5'b00010, 3'b101, 6'b010001, 1'b0, 1'b1));
    push(hw(5'b00010, 3'b011, 6'b111000, 1'b0, 1'b0));
    // R10: 10-bit store, single halfword run
    push(hw(MAJ, 3'b111, 6'b011110, 1'b1, 1'b0));
    push(16'hFFFF); push(16'h0001);
    // mixed random stream
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      if ($urandom_range(2) == 0) r[15:11] = MAJ;
      push(r);
    end

    while (eq.size() > 0) begin
      @(negedge clk);
      if (stall) begin
        checks++;   // R12 record held while stalled
        if (!out_valid || out_raw != s_raw || out_op != s_op) begin
          errors++;
          $display("FAIL R12 stall hold act v=%b raw=%h op=%0d exp v=1 raw=%h op=%0d",
                   out_valid, out_raw, out_op, s_raw, s_op);
        end
      end
      if (acc) in_valid = 1'b0;
      if (!in_valid && pq.size() > 0 && $urandom_range(4) != 0) begin
        in_parcel = pq.pop_front();
        in_valid = 1'b1;
      end
      out_ready = ($urandom_range(3) != 0);
      #1;
      if (in_ready !== (!out_valid || out_ready)) begin
        checks++; errors++;
        $display("FAIL R12 in_ready act=%b exp=%b", in_ready, !out_valid || out_ready);
      end
      if (out_valid && out_ready) check_rec(eq.pop_front());
      stall = out_valid && !out_ready;
      s_raw = out_raw; s_op = out_op;
      acc = in_valid && in_ready;
    end
    done = 1;
    summary();
  end
endmodule